// File: doc/BRIEF.md
# Wait-State Memory Bus Master

This block turns single transfer requests into read and write cycles on an external bus with separate address, data and control lines. It targets a slow, byte-addressable memory. A requester offers one operation at a time: a direction bit, a byte address and, for writes, a data byte.

Each cycle runs in a fixed order. First the controller presents the address, and for a write also the data. In the next cycle it pulls the matching active-low strobe. It keeps that strobe low until the memory raises its ready line. For a read it takes the data bus value at that same edge. It then releases the strobe and flags completion with a single-cycle pulse. Because the length of the wait comes from the ready line, one controller serves both fast and slow memories.

The data bus is modelled as a separate output value, an output-enable and an input value, so that the pad-level tri-state stays outside the block. The parameter `MIN_LOW` sets the shortest strobe-low time (default 2 cycles).

Top module: `membus_master`

## Requirements
- R1: While reset is applied and right after it, the controller is idle: `rd_n` and `wr_n` are 1, `bus_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: A request is taken only at a rising edge where `req_ready` is 1 and `req_valid` is 1. While a transfer is in progress, `req_ready` is 0, and `req_valid` or new request fields have no effect on the bus or on the number of completions.
- R3: `bus_addr` carries the requested address for at least one full cycle before a strobe falls, and it stays unchanged while the strobe is low.
- R4: On a write (`req_write`=1), `bus_oe` is 1 and `bus_dout` holds the write byte from the cycle before `wr_n` falls, through the strobe-low period, until the cycle after `wr_n` rises. The byte is therefore stored at the requested address.
- R5: A strobe stays low for at least `MIN_LOW` cycles. After that it stays low until `mem_rdy` is sampled 1 at a rising edge, and it returns high on that same edge. With a memory that raises ready in its k-th strobe-low cycle, the strobe is low for max(`MIN_LOW`, k) cycles.
- R6: On a read, `rd_data` takes the value of `bus_din` at the rising edge that ends the strobe-low period, while `rd_n` is still low. It holds that value from the completion cycle until the next read completes.
- R7: `done` is 1 for exactly one cycle: the first cycle after a strobe returns high. It is 0 at all other times.
- R8: `rd_n` and `wr_n` are never low together, and `bus_oe` is 0 outside write transfers, in particular whenever `rd_n` is low.
- R9: Addresses are byte addresses and go to `bus_addr` unchanged: odd addresses and the all-ones address are not aligned or masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | DW | Byte to write |
| req_ready | output | 1 | Controller idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Byte returned by the last read |
| bus_addr | output | AW | External address bus |
| bus_dout | output | DW | Value driven onto the data bus |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | DW | Value seen on the data bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mem_rdy | input | 1 | Memory ready, ends the wait period |

## Verification
A wrong sequencer state shows up at the ports within the same cycle. The symptoms are a strobe falling with no setup cycle, a strobe-low length different from max(`MIN_LOW`, k), or a `done` pulse that is missing, doubled or late. The bench measures all of these against the ready latency it programs for each transfer. A stale address or data latch is seen while the strobe is low, as a wrong `bus_addr` or `bus_dout`. A capture at the wrong edge returns the bench memory's filler byte instead of the stored byte, and this shows up in the completion cycle.

// File: rtl/membus_pkg.sv
// Shared types for the wait-state memory bus master.
package membus_pkg;

    // Bus cycle phases; order only matters for readability.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_FINISH = 2'd3
    } bus_state_t;

endpackage

// File: rtl/membus_seq.sv
// Cycle sequencer: idle -> setup (address/data out, strobes high) ->
// strobe low for at least MIN_LOW cycles and until ready -> finish.
// Assumes MIN_LOW >= 1 and a synchronous active-low reset.
module membus_seq
    import membus_pkg::*;
#(
    parameter int MIN_LOW = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       mem_rdy,
    output bus_state_t state,
    output logic       accept,
    output logic       capture
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LOW_LAST = CW'(MIN_LOW - 1);

    logic [CW-1:0] low_cnt;
    logic          low_met;

    // Minimum strobe time has elapsed in the current strobe cycle.
    always_comb low_met = (low_cnt >= LOW_LAST);

    // Handshake and capture strobes decoded from the phase.
    always_comb begin
        accept  = (state == ST_IDLE) && req_valid;
        capture = (state == ST_STROBE) && mem_rdy && low_met;
    end

    // Phase register and strobe-low counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            low_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) state <= ST_SETUP;
                end
                ST_SETUP: begin
                    state   <= ST_STROBE;
                    low_cnt <= '0;
                end
                ST_STROBE: begin
                    if (mem_rdy && low_met) state <= ST_FINISH;
                    else if (!low_met)      low_cnt <= low_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    low_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STROBE) |=> (state != ST_FINISH) || $past(state == ST_STROBE));

endmodule

// File: rtl/membus_datapath.sv
// Request latches and read capture register. Holds the address and write
// byte for the whole bus cycle; samples the data bus on the capture pulse.
// Assumes accept and capture never occur in the same cycle.
module membus_datapath #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_din,
    output logic          is_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic [DW-1:0] rd_data
);
    // Latch the request fields when a new cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_write <= 1'b0;
            bus_addr <= '0;
            bus_dout <= '0;
        end else if (accept) begin
            is_write <= req_write;
            bus_addr <= req_addr;
            bus_dout <= req_wdata;
        end
    end

    // Sample returned data while the read strobe is still low.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_data <= '0;
        else if (capture && !is_write) rd_data <= bus_din;
    end

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && capture));

endmodule

// File: rtl/membus_master.sv
// Top of the wait-state memory bus master. Runs one read or write at a
// time on a separate address/data/strobe bus; strobe length follows the
// memory ready input. Data bus is split into out/enable/in for pad logic.
module membus_master
    import membus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int MIN_LOW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_din,
    output logic          rd_n,
    output logic          wr_n,
    input  logic          mem_rdy
);
    bus_state_t state;
    logic       accept;
    logic       capture;
    logic       is_write;

    membus_seq #(.MIN_LOW(MIN_LOW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .mem_rdy   (mem_rdy),
        .state     (state),
        .accept    (accept),
        .capture   (capture)
    );

    membus_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_din   (bus_din),
        .is_write  (is_write),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .rd_data   (rd_data)
    );

    // Decode strobes, output enable and handshake from the phase.
    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_FINISH);
        rd_n      = !((state == ST_STROBE) && !is_write);
        wr_n      = !((state == ST_STROBE) && is_write);
        bus_oe    = is_write && (state != ST_IDLE);
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R8
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> $stable(bus_addr));

    // R4
    wdata_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> ($past(bus_oe) && $stable(bus_dout)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && $past(!rd_n || !wr_n)));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !done) |=> $stable(bus_addr));

    generate
        if (MIN_LOW >= 2) begin : g_min_low
            // R5
            min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(rd_n) || $fell(wr_n)) |=> (!rd_n || !wr_n));
        end
    endgenerate

endmodule

// File: tb/test_membus_master.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task queues expected transfers, and the
// monitor pops and checks them while also playing the slow memory.
module test_membus_master;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int MIN_LOW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done, bus_oe, rd_n, wr_n;
    logic [DW-1:0] rd_data, bus_dout, bus_din;
    logic [AW-1:0] bus_addr;
    logic          mem_rdy = 1'b0;

    typedef struct {
        bit            wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            len;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] mem_model [16];
    logic [DW-1:0] ref_mem   [16];
    int            n_checks = 0;
    int            n_fail   = 0;
    int            wait_cfg = 1;
    int            lowcnt   = 0;
    int            n_push   = 0;
    int            n_done   = 0;
    bit            prev_low = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_dout = '0;
    bit            prev_oe  = 1'b0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;

    membus_master #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW)) i_membus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din), .rd_n(rd_n), .wr_n(wr_n),
        .mem_rdy(mem_rdy)
    );

    // Memory returns valid bytes only when ready during a read strobe.
    assign bus_din = (!rd_n && mem_rdy) ? mem_model[bus_addr[3:0]] : 8'hEE;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Driver: queue the expectation, offer the request, optionally keep
    // pushing a bogus request while busy, and wait for completion.
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int wt, input bit intrude);
        exp_t e;
        while (!req_ready) @(negedge clk);
        e.wr  = wr;
        e.a   = a;
        e.d   = wr ? d : ref_mem[a[3:0]];
        e.len = (wt > MIN_LOW) ? wt : MIN_LOW;
        if (wr) ref_mem[a[3:0]] = d;
        exp_q.push_back(e);
        n_push++;
        wait_cfg  = wt;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
        if (intrude) begin
            req_write = ~wr;
            req_addr  = a ^ 16'h00F0;
            req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor and memory model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit strobe_low = !rd_n || !wr_n;
            if (strobe_low) begin
                lowcnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 strobe with no request", 1, 0);
                end else begin
                    if (lowcnt == 1) begin
                        // R3 address set up a cycle before strobe
                        chk(prev_addr == exp_q[0].a, "R3 addr setup", prev_addr, exp_q[0].a);
                        if (exp_q[0].wr)
                            chk(prev_oe && prev_dout == exp_q[0].d, "R4 data setup",
                                prev_dout, exp_q[0].d);
                    end
                    // R9 exact byte address
                    chk(bus_addr == exp_q[0].a, "R9 addr on bus", bus_addr, exp_q[0].a);
                    chk(!wr_n == exp_q[0].wr, "R8 strobe select", wr_n, !exp_q[0].wr);
                    if (exp_q[0].wr)
                        chk(bus_oe && bus_dout == exp_q[0].d, "R4 data driven",
                            bus_dout, exp_q[0].d);
                    else
                        chk(!bus_oe, "R8 no drive on read", bus_oe, 0);
                end
                if (!wr_n) mem_model[bus_addr[3:0]] = bus_dout;
                mem_rdy = (lowcnt >= wait_cfg);
            end else begin
                mem_rdy = 1'b0;
            end
            if (done) begin
                n_done++;
                chk(prev_low && !strobe_low, "R7 done follows release", prev_low, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 extra completion", 1, 0);
                end else begin
                    automatic exp_t e = exp_q.pop_front();
                    chk(lowcnt == e.len, "R5 strobe low length", lowcnt, e.len);
                    if (e.wr) begin
                        chk(mem_model[e.a[3:0]] == e.d, "R4 stored byte",
                            mem_model[e.a[3:0]], e.d);
                        chk(bus_oe && bus_dout == e.d, "R4 data hold after strobe",
                            bus_dout, e.d);
                    end else begin
                        chk(rd_data == e.d, "R6 read data", rd_data, e.d);
                    end
                end
                lowcnt = 0;
            end else if (prev_low && !strobe_low) begin
                chk(1'b0, "R7 done missing", 0, 1);
                lowcnt = 0;
            end
            prev_low  = strobe_low;
            prev_addr = bus_addr;
            prev_dout = bus_dout;
            prev_oe   = bus_oe;
        end
    end

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_model[i] = 8'(i * 17) ^ 8'h5A;
            ref_mem[i]   = 8'(i * 17) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_n && wr_n, "R1 strobes high in reset", {rd_n, wr_n}, 2'b11);
        chk(!bus_oe && !done, "R1 bus idle in reset", {bus_oe, done}, 0);
        chk(req_ready, "R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_n && wr_n && !bus_oe && req_ready && !done, "R1 idle after reset",
            {rd_n, wr_n, bus_oe, req_ready, done}, 5'b11010);

        issue(1'b1, 16'h1234, 8'hA5, 0, 1'b0);
        issue(1'b0, 16'h1234, 8'h00, 1, 1'b0);
        issue(1'b0, 16'h0003, 8'h00, 3, 1'b0);
        issue(1'b1, 16'hFFFF, 8'h3C, 5, 1'b0);
        issue(1'b0, 16'hFFFF, 8'h00, 2, 1'b0);
        // R2 requests while busy are ignored
        issue(1'b1, 16'h00A1, 8'h77, 4, 1'b1);
        issue(1'b0, 16'h00A1, 8'h00, 0, 1'b1);
        for (int k = 0; k < 12; k++) begin
            issue(k[0], 16'(k * 16'h0123 + 1), 8'(k * 29), k % 6, 1'b0);
        end
        issue(1'b0, 16'h0007, 8'h00, 7, 1'b0);

        repeat (10) @(negedge clk);
        // R2 completion count matches accepted requests
        chk(n_done == n_push && exp_q.size() == 0, "R2 completions", n_done, n_push);
        chk(rd_n && wr_n && !bus_oe && req_ready, "R2 idle at end",
            {rd_n, wr_n, bus_oe, req_ready}, 4'b1101);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule